// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block brings a mobile synchronous DRAM from reset to a usable state. The device needs a long quiet period after power-on, then a fixed set of commands. From reset the block drives a no-operation command on the command pins, with clock enable and the data masks held high so that nothing can drive the data bus. It counts the pause in clock cycles. It then issues a precharge of all banks and programs the mode register with CAS latency 3 and the chosen burst settings. It also issues a set number of auto-refresh commands. Each command is spaced by the device's timing limits, converted from nanoseconds to clocks and rounded up.

When the last wait has expired, `init_done` rises and stays high until the next reset. The bus is left at no-operation, and the normal memory controller takes over the pins. One parameter chooses whether the refreshes run before or after the mode-register set. Other parameters give the clock period, the pause length, the device timings and the mode-register fields.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is high, and from reset release until the pause ends, the command is no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1), cke=1, every dqm bit is 1, and init_done=0. cke and dqm stay high for the whole sequence.
- R2: The pause lasts PAUSE_CYC = ceil(PAUSE_NS*1000/CLK_PERIOD_PS) clocks. The first command other than no-operation appears in the cycle that follows the PAUSE_CYC-th rising edge after reset release. With the defaults (20000 ps, 200000 ns) that is 10000.
- R3: The first command is a precharge of all banks: cs_n=0, ras_n=0, cas_n=1, we_n=0, with addr[10]=1.
- R4: The mode-register set is encoded cs_n=ras_n=cas_n=we_n=0 with ba=0. Its address is addr[2:0]=BURST_CODE, addr[3]=INTERLEAVE, addr[6:4]=3'b011 (CAS latency 3) and addr[9]=SINGLE_WRITE, with every other bit 0.
- R5: Exactly REF_COUNT (default 8) auto-refresh commands are issued, each encoded cs_n=0, ras_n=0, cas_n=0, we_n=1.
- R6: The command after the precharge comes ceil(TRP_NS*1000/CLK_PERIOD_PS) clocks later, with a minimum of 1. Each command after a refresh comes ceil(TRFC_NS*1000/CLK_PERIOD_PS) clocks later.
- R7: After the mode-register set, at least MRS_GAP (default 2) no-operation cycles follow. The next command comes MRS_GAP+1 clocks after the mode-register set.
- R8: With REFRESH_FIRST=0 the order is precharge, mode-register set, then the refreshes. With REFRESH_FIRST=1 the order is precharge, the refreshes, then the mode-register set.
- R9: init_done rises one wait after the last command. That wait is the refresh spacing when the last command is a refresh, or MRS_GAP+1 when it is the mode-register set. init_done then stays high, and the command stays no-operation.
- R10: Asserting reset at any point, including mid-sequence, returns the outputs to the R1 state on the next edge. After release the whole sequence restarts, with the precharge again PAUSE_CYC edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | DRAM clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select |
| addr | output | ADDR_W | Address bus, carries A10 and the mode word |
| dqm | output | DQM_W | Data masks, held high |
| init_done | output | 1 | High once the start-up sequence has finished |

## Verification
Each command is visible in the cycle after the rising edge on which its wait expires. The precharge therefore falls PAUSE_CYC edges after release, and each later command falls exactly its spacing after the previous one. init_done falls one spacing after the final command, and after reset the outputs return to their idle state one edge later. The bench counts rising edges from reset release and samples every output on the falling edge. Each non-idle command is logged with its cycle index and compared against a table of expected cycles derived from the rounding rule. Two configurations are run, with different clock periods, orders and mode fields, along with a reset after completion and a reset in mid-sequence.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PALL = 2'd1,
        CMD_MRS  = 2'd2,
        CMD_REF  = 2'd3
    } sdram_cmd_e;

    typedef enum logic [1:0] {
        NX_PALL = 2'd0,
        NX_MRS  = 2'd1,
        NX_REF  = 2'd2,
        NX_DONE = 2'd3
    } init_step_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam logic [2:0] CAS_LAT3_CODE = 3'b011;

    // nanoseconds to whole clocks, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_pins_t encode_cmd(input sdram_cmd_e c);
        cmd_pins_t p;
        unique case (c)
            CMD_PALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_MRS:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

    function automatic logic [12:0] mode_word(input logic [2:0] burst_code,
                                              input logic       interleave,
                                              input logic       single_write);
        logic [12:0] w;
        w      = '0;
        w[2:0] = burst_code;
        w[3]   = interleave;
        w[6:4] = CAS_LAT3_CODE;
        w[9]   = single_write;
        return w;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned TW      = 16,
    parameter int unsigned RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= TW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R6
    hold_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int unsigned TW            = 16,
    parameter int unsigned TRP_CYC       = 1,
    parameter int unsigned TRFC_CYC      = 4,
    parameter int unsigned MRS_GAP       = 2,
    parameter int unsigned REF_COUNT     = 8,
    parameter bit          REFRESH_FIRST = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          expired,
    output logic          load,
    output logic [TW-1:0] load_val,
    output sdram_cmd_e    cmd_q,
    output logic          done_q
);

    localparam int unsigned RCW      = $clog2(REF_COUNT + 1);
    localparam int unsigned MRS_SPAN = MRS_GAP + 1;

    init_step_e     step_q, step_nx;
    logic [RCW-1:0] ref_cnt_q, ref_cnt_nx;
    sdram_cmd_e     cmd_sel;
    int unsigned    gap;
    logic           issue;

    always_comb begin
        cmd_sel    = CMD_NOP;
        gap        = 1;
        step_nx    = step_q;
        ref_cnt_nx = ref_cnt_q;
        unique case (step_q)
            NX_PALL: begin
                cmd_sel = CMD_PALL;
                gap     = TRP_CYC;
                step_nx = REFRESH_FIRST ? NX_REF : NX_MRS;
            end
            NX_MRS: begin
                cmd_sel = CMD_MRS;
                gap     = MRS_SPAN;
                step_nx = REFRESH_FIRST ? NX_DONE : NX_REF;
            end
            NX_REF: begin
                cmd_sel    = CMD_REF;
                gap        = TRFC_CYC;
                ref_cnt_nx = ref_cnt_q + 1'b1;
                if (ref_cnt_q == RCW'(REF_COUNT - 1)) begin
                    step_nx = REFRESH_FIRST ? NX_MRS : NX_DONE;
                end
            end
            default: ;
        endcase
    end

    assign issue    = expired && (step_q != NX_DONE);
    assign load     = issue;
    assign load_val = TW'(gap - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= NX_PALL;
            ref_cnt_q <= '0;
            cmd_q     <= CMD_NOP;
            done_q    <= 1'b0;
        end else begin
            cmd_q <= issue ? cmd_sel : CMD_NOP;
            if (issue) begin
                step_q    <= step_nx;
                ref_cnt_q <= ref_cnt_nx;
            end
            if (expired && step_q == NX_DONE) begin
                done_q <= 1'b1;
            end
        end
    end

    // R2
    issue_on_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q != CMD_NOP) |-> $past(expired));

    // R5
    ref_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ref_cnt_q <= RCW'(REF_COUNT));

    // R7
    mrs_gap1_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_q) == CMD_MRS) |-> (cmd_q == CMD_NOP));

    if (MRS_GAP >= 2) begin : g_gap2
        // R7
        mrs_gap2_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(cmd_q, 2) == CMD_MRS) |-> (cmd_q == CMD_NOP));
    end

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);

    // R9
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cmd_q == CMD_NOP));

endmodule

// File: rtl/sdram_init_cmd_drv.sv
module sdram_init_cmd_drv
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned BA_W         = 2,
    parameter int unsigned DQM_W        = 2,
    parameter logic [2:0]  BURST_CODE   = 3'b011,
    parameter bit          INTERLEAVE   = 1'b0,
    parameter bit          SINGLE_WRITE = 1'b0
) (
    input  sdram_cmd_e        cmd,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DQM_W-1:0]  dqm
);

    localparam logic [ADDR_W-1:0] MODE_VAL =
        ADDR_W'(mode_word(BURST_CODE, INTERLEAVE, SINGLE_WRITE));

    cmd_pins_t pins;

    always_comb begin
        pins = encode_cmd(cmd);
        addr = '0;
        unique case (cmd)
            CMD_PALL: addr[10] = 1'b1;
            CMD_MRS:  addr     = MODE_VAL;
            default:  ;
        endcase
    end

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign ba    = '0;
    assign cke   = 1'b1;
    assign dqm   = '1;

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned PAUSE_NS      = 200000,
    parameter int unsigned TRP_NS        = 18,
    parameter int unsigned TRFC_NS       = 72,
    parameter int unsigned REF_COUNT     = 8,
    parameter int unsigned MRS_GAP       = 2,
    parameter bit          REFRESH_FIRST = 1'b0,
    parameter logic [2:0]  BURST_CODE    = 3'b011,
    parameter bit          INTERLEAVE    = 1'b0,
    parameter bit          SINGLE_WRITE  = 1'b0,
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned BA_W          = 2,
    parameter int unsigned DQM_W         = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DQM_W-1:0]  dqm,
    output logic              init_done
);

    localparam int unsigned PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_PERIOD_PS);
    localparam int unsigned TRP_CYC   = ns_to_cyc(TRP_NS, CLK_PERIOD_PS);
    localparam int unsigned TRFC_CYC  = ns_to_cyc(TRFC_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_WAIT  =
        max2(max2(PAUSE_CYC, TRP_CYC), max2(TRFC_CYC, MRS_GAP + 1));
    localparam int unsigned TW        = $clog2(MAX_WAIT + 1);

    logic          expired;
    logic          load;
    logic [TW-1:0] load_val;
    sdram_cmd_e    cmd_q;

    sdram_init_timer #(
        .TW      (TW),
        .RST_VAL (PAUSE_CYC - 1)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sdram_init_fsm #(
        .TW            (TW),
        .TRP_CYC       (TRP_CYC),
        .TRFC_CYC      (TRFC_CYC),
        .MRS_GAP       (MRS_GAP),
        .REF_COUNT     (REF_COUNT),
        .REFRESH_FIRST (REFRESH_FIRST)
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .cmd_q    (cmd_q),
        .done_q   (init_done)
    );

    sdram_init_cmd_drv #(
        .ADDR_W       (ADDR_W),
        .BA_W         (BA_W),
        .DQM_W        (DQM_W),
        .BURST_CODE   (BURST_CODE),
        .INTERLEAVE   (INTERLEAVE),
        .SINGLE_WRITE (SINGLE_WRITE)
    ) drv_i (
        .cmd   (cmd_q),
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr),
        .dqm   (dqm)
    );

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_NOP) |-> (!cs_n && ras_n && cas_n && we_n));

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (!init_done && cmd_q == CMD_NOP));

endmodule

// File: tb/sdram_powerup_seq_tb.sv
`timescale 1ns/1ps
module sdram_powerup_seq_tb_top;

    localparam logic [2:0] C_NOP  = 3'd0;
    localparam logic [2:0] C_PALL = 3'd1;
    localparam logic [2:0] C_MRS  = 3'd2;
    localparam logic [2:0] C_REF  = 3'd3;
    localparam logic [2:0] C_BAD  = 3'd7;

    // configuration A: 20 ns clock, MRS first, burst 8 sequential
    localparam int PA    = 10000;
    localparam int TRP_A = 1;
    localparam int RF_A  = 4;
    localparam int MG    = 3;
    localparam int DONE_A = PA + TRP_A + MG + 8 * RF_A;
    // configuration B: 6 ns period, refresh first, burst 4 interleave, single write
    localparam int PB    = 33334;
    localparam int TRP_B = 3;
    localparam int RF_B  = 12;
    localparam int DONE_B = PB + TRP_B + 8 * RF_B + MG;
    localparam int RUN_LEN = DONE_B + 40;

    typedef struct packed {
        logic [2:0]  cmd;
        logic [31:0] at;
        logic [12:0] addr;
        logic [12:0] mask;
    } ev_t;

    localparam ev_t EXP_A [10] = '{
        '{C_PALL, 32'(PA),                             13'h400, 13'h400},
        '{C_MRS,  32'(PA + TRP_A),                     13'h033, 13'h1FFF},
        '{C_REF,  32'(PA + TRP_A + MG + 0 * RF_A),     13'h000, 13'h000},
        '{C_REF,  32'(PA + TRP_A + MG + 1 * RF_A),     13'h000, 13'h000},
        '{C_REF,  32'(PA + TRP_A + MG + 2 * RF_A),     13'h000, 13'h000},
        '{C_REF,  32'(PA + TRP_A + MG + 3 * RF_A),     13'h000, 13'h000},
        '{C_REF,  32'(PA + TRP_A + MG + 4 * RF_A),     13'h000, 13'h000},
        '{C_REF,  32'(PA + TRP_A + MG + 5 * RF_A),     13'h000, 13'h000},
        '{C_REF,  32'(PA + TRP_A + MG + 6 * RF_A),     13'h000, 13'h000},
        '{C_REF,  32'(PA + TRP_A + MG + 7 * RF_A),     13'h000, 13'h000}
    };

    localparam ev_t EXP_B [10] = '{
        '{C_PALL, 32'(PB),                        13'h400, 13'h400},
        '{C_REF,  32'(PB + TRP_B + 0 * RF_B),     13'h000, 13'h000},
        '{C_REF,  32'(PB + TRP_B + 1 * RF_B),     13'h000, 13'h000},
        '{C_REF,  32'(PB + TRP_B + 2 * RF_B),     13'h000, 13'h000},
        '{C_REF,  32'(PB + TRP_B + 3 * RF_B),     13'h000, 13'h000},
        '{C_REF,  32'(PB + TRP_B + 4 * RF_B),     13'h000, 13'h000},
        '{C_REF,  32'(PB + TRP_B + 5 * RF_B),     13'h000, 13'h000},
        '{C_REF,  32'(PB + TRP_B + 6 * RF_B),     13'h000, 13'h000},
        '{C_REF,  32'(PB + TRP_B + 7 * RF_B),     13'h000, 13'h000},
        '{C_MRS,  32'(PB + TRP_B + 8 * RF_B),     13'h23A, 13'h1FFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba, a_dqm;
    logic [12:0] a_addr;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba, b_dqm;
    logic [12:0] b_addr;

    sdram_powerup_seq dut_i (
        .clk(clk), .rst(rst), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras),
        .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .dqm(a_dqm),
        .init_done(a_done)
    );

    sdram_powerup_seq #(
        .CLK_PERIOD_PS(6000), .REFRESH_FIRST(1'b1), .BURST_CODE(3'b010),
        .INTERLEAVE(1'b1), .SINGLE_WRITE(1'b1)
    ) dut_rf_i (
        .clk(clk), .rst(rst), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras),
        .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .dqm(b_dqm),
        .init_done(b_done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic logic [2:0] dec(input logic cs, input logic ras,
                                       input logic cas, input logic we);
        if (cs) return C_BAD;
        case ({ras, cas, we})
            3'b111:  return C_NOP;
            3'b010:  return C_PALL;
            3'b000:  return C_MRS;
            3'b001:  return C_REF;
            default: return C_BAD;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            C_PALL:  return "R3 R2";
            C_MRS:   return "R4 R8";
            default: return "R6 R5";
        endcase
    endfunction

    ev_t got_a [10];
    ev_t got_b [10];

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        int n_a = 0, n_b = 0, done_at_a = 0, done_at_b = 0;
        int mrs_pos_a = -1, mrs_pos_b = -1, refs_a = 0, refs_b = 0;
        bit pause_bad_a = 0, pause_bad_b = 0, post_bad_a = 0, post_bad_b = 0;
        bit hold_bad = 0, ba_bad = 0;
        int first_at;
        logic [2:0] ca, cb, c;

        // R1: state while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dec(a_cs, a_ras, a_cas, a_we) == C_NOP && a_cke && a_dqm == 2'b11 && !a_done,
            "R1", "reset state A", int'(a_done), 0);
        chk(dec(b_cs, b_ras, b_cas, b_we) == C_NOP && b_cke && b_dqm == 2'b11 && !b_done,
            "R1", "reset state B", int'(b_done), 0);
        rst = 1'b0;

        for (int cyc = 1; cyc <= RUN_LEN; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            ca = dec(a_cs, a_ras, a_cas, a_we);
            cb = dec(b_cs, b_ras, b_cas, b_we);
            if (!a_cke || a_dqm != 2'b11 || !b_cke || b_dqm != 2'b11) hold_bad = 1;
            if (ca != C_NOP) begin
                if (n_a < 10) got_a[n_a] = '{ca, 32'(cyc), a_addr, 13'h0};
                if (ca == C_MRS) begin mrs_pos_a = n_a; if (a_ba != 0) ba_bad = 1; end
                if (ca == C_REF) refs_a++;
                n_a++;
            end
            if (cb != C_NOP) begin
                if (n_b < 10) got_b[n_b] = '{cb, 32'(cyc), b_addr, 13'h0};
                if (cb == C_MRS) begin mrs_pos_b = n_b; if (b_ba != 0) ba_bad = 1; end
                if (cb == C_REF) refs_b++;
                n_b++;
            end
            if (cyc < PA && (ca != C_NOP || a_done)) pause_bad_a = 1;
            if (cyc < PB && (cb != C_NOP || b_done)) pause_bad_b = 1;
            if (a_done && done_at_a == 0) done_at_a = cyc;
            if (b_done && done_at_b == 0) done_at_b = cyc;
            if (done_at_a != 0 && (!a_done || ca != C_NOP)) post_bad_a = 1;
            if (done_at_b != 0 && (!b_done || cb != C_NOP)) post_bad_b = 1;
        end

        chk(!pause_bad_a, "R1", "quiet pause A", int'(pause_bad_a), 0);
        chk(!pause_bad_b, "R1", "quiet pause B", int'(pause_bad_b), 0);
        chk(!hold_bad, "R1", "cke/dqm held high", int'(hold_bad), 0);
        chk(n_a == 10, "R5", "command count A", n_a, 10);
        chk(n_b == 10, "R5", "command count B", n_b, 10);
        chk(refs_a == 8 && refs_b == 8, "R5", "refresh count A", refs_a, 8);

        // table walk: command, cycle, address field
        for (int i = 0; i < 10; i++) begin
            chk(got_a[i].cmd == EXP_A[i].cmd && got_a[i].at == EXP_A[i].at &&
                (got_a[i].addr & EXP_A[i].mask) == EXP_A[i].addr,
                tag_of(EXP_A[i].cmd), $sformatf("A event %0d cycle", i),
                int'(got_a[i].at), int'(EXP_A[i].at));
            chk(got_b[i].cmd == EXP_B[i].cmd && got_b[i].at == EXP_B[i].at &&
                (got_b[i].addr & EXP_B[i].mask) == EXP_B[i].addr,
                tag_of(EXP_B[i].cmd), $sformatf("B event %0d cycle", i),
                int'(got_b[i].at), int'(EXP_B[i].at));
        end

        chk(!ba_bad, "R4", "mode set bank bits", int'(ba_bad), 0);
        chk(got_a[2].at - got_a[1].at == 32'(MG), "R7", "gap after mode set A",
            int'(got_a[2].at - got_a[1].at), MG);
        chk(mrs_pos_a == 1, "R8", "mode set position A", mrs_pos_a, 1);
        chk(mrs_pos_b == 9, "R8", "mode set position B", mrs_pos_b, 9);
        chk(done_at_a == DONE_A, "R9", "done cycle A", done_at_a, DONE_A);
        chk(done_at_b == DONE_B, "R9", "done cycle B", done_at_b, DONE_B);
        chk(!post_bad_a && !post_bad_b, "R9", "done sticky and quiet",
            int'(post_bad_a || post_bad_b), 0);

        // R10: reset after completion
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(!a_done && dec(a_cs, a_ras, a_cas, a_we) == C_NOP && a_cke && a_dqm == 2'b11,
            "R10", "reset after done", int'(a_done), 0);
        rst = 1'b0;

        // R10: restart, then reset mid-sequence
        first_at = 0;
        for (int cyc = 1; cyc <= PA + 6; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            c = dec(a_cs, a_ras, a_cas, a_we);
            if (c != C_NOP && first_at == 0) first_at = cyc;
        end
        chk(first_at == PA, "R10", "restart precharge cycle", first_at, PA);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(!a_done && dec(a_cs, a_ras, a_cas, a_we) == C_NOP,
            "R10", "mid-sequence reset idle", int'(dec(a_cs, a_ras, a_cas, a_we)), 0);
        rst = 1'b0;
        first_at = 0;
        for (int cyc = 1; cyc <= PA + 1; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            c = dec(a_cs, a_ras, a_cas, a_we);
            if (c != C_NOP && first_at == 0) begin
                first_at = cyc;
                chk(c == C_PALL && a_addr[10], "R10", "restart command is precharge",
                    int'(c), int'(C_PALL));
            end
        end
        chk(first_at == PA, "R10", "precharge after mid reset", first_at, PA);

        wrap_up();
    end

endmodule